// File: doc/BRIEF.md
# Mirrored Register Access Stretcher

This block sits between the masters of a 16-bit on-chip peripheral bus and the peripheral register file. Some byte addresses belong to registers that an external emulator keeps a copy of. An access that touches one of these mirrored registers is held for extra bus cycles through the ready signal. A word access at an odd address is split into two byte transfers. The block also decides, from the operating mode, which copy a read comes from and which copies a write updates.

Outside emulation mode, the internal register file is the only target. In emulation mode, a write to a mirrored register updates the internal copy and the external copy in the same cycle, and a read of a mirrored register takes its data from the external copy. The extra cycles are added in every mode, so timing is the same whether or not an emulator is attached. When the coprocessor or the debug master touches a mirrored register, the block also asks for the main CPU to be halted for the whole access.

Top module: `mreg_stretch`

## Requirements
- R1: An access that touches no mirrored byte completes in the cycle it is presented (a byte, or a word at an even address) or in 2 cycles (a word at an odd address). It uses only the internal port, and the emulation port stays idle.
- R2: A byte access, or a word access at an even address, that touches at least one mirrored byte completes in 2 cycles, with the emulation mode input either 0 or 1. A word at an even address that touches one mirrored byte is routed as mirrored in both byte lanes.
- R3: A word access at an odd address whose two bytes are both mirrored completes in 4 cycles.
- R4: A word access at an odd address with exactly one mirrored byte completes in 3 cycles, whichever of the two bytes is the mirrored one.
- R5: A word access at odd address A is done as two byte transfers, A first and then A+1, and ready is high only in the final cycle. Bus data bits 7:0 carry the byte at A and bits 15:8 carry the byte at A+1. Byte accesses use bus bits 7:0. On the register ports, the even byte of a word is bits 7:0 with byte enable bit 0, and the odd byte is bits 15:8 with byte enable bit 1.
- R6: In emulation mode (emu_mode=1), a write to a mirrored byte strobes the internal port and the emulation port in the same cycle, with the same address, byte enables and data.
- R7: In emulation mode, a read of a mirrored byte returns emulation-port data. With emu_mode=0, every read returns internal data and the emulation port is never enabled. A write with emu_mode=0 leaves the external copy unchanged.
- R8: cpu_halt is high in every cycle of an access by a master whose code is not 0 (1 is the coprocessor, 2 is the debug master, 3 is treated the same way) that touches a mirrored byte. It is low in the cycle after ready unless another such access is already running. An access by master code 0 (the CPU) never raises cpu_halt.
- R9: Each byte transfer strobes its port in exactly one cycle, the last cycle of that transfer.
- R10: A byte is mirrored exactly when its address equals an entry of the MIR_LIST parameter (default 0x030, 0x031, 0x032, 0x036, 0x039). Neighbouring addresses such as 0x033 are not mirrored.
- R11: During reset and while no request is present, ready, cpu_halt and both port enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode | input | 1 | 1 when the chip runs in an emulation mode |
| bus_req | input | 1 | Access request, held until ready |
| bus_master | input | 2 | Requesting master: 0 CPU, 1 coprocessor, 2 debug, 3 other non-CPU |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_word | input | 1 | 1 for a 16-bit access, 0 for a byte |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the ready cycle |
| bus_ready | output | 1 | Access completes in this cycle |
| cpu_halt | output | 1 | Halt request to the main CPU |
| int_en | output | 1 | Internal register file strobe |
| int_wr | output | 1 | Internal write when 1 |
| int_addr | output | AW | Word-aligned internal address |
| int_be | output | 2 | Internal byte enables |
| int_wdata | output | 16 | Internal write data |
| int_rdata | input | 16 | Internal read data, same cycle |
| emu_en | output | 1 | Emulation port strobe |
| emu_wr | output | 1 | Emulation port write when 1 |
| emu_addr | output | AW | Word-aligned emulation address |
| emu_be | output | 2 | Emulation port byte enables |
| emu_wdata | output | 16 | Emulation port write data |
| emu_rdata | input | 16 | Emulation port read data, same cycle |

## Verification
The assertions assume that a master keeps its request, address, size, direction and data unchanged from the first cycle until ready, and that only one master drives the bus at a time. They also assume that both register ports return read data in the cycle they are strobed. The bench changes bus inputs only just after a rising edge and releases or replaces a request only after the edge on which ready was high. Its register-file models answer reads combinationally from the address on the port.

// File: rtl/mreg_pkg.sv
package mreg_pkg;

  typedef enum logic [1:0] {
    MST_CPU = 2'd0,
    MST_COP = 2'd1,
    MST_DBG = 2'd2,
    MST_AUX = 2'd3
  } master_e;

  // Place one byte on the lane selected by the low address bit (R5).
  function automatic logic [15:0] lane_put(input logic odd, input logic [7:0] b);
    return odd ? {b, 8'h00} : {8'h00, b};
  endfunction

endpackage

// File: rtl/mreg_match.sv
module mreg_match #(
  parameter int              AW    = 10,
  parameter int              N     = 5,
  parameter logic [N*AW-1:0] LIST  = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [N-1:0] eq;

  // R10: one comparator per listed byte address
  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign eq[gi] = (addr == LIST[gi*AW +: AW]);
  end

  assign hit = |eq;

endmodule

// File: rtl/mreg_seq.sv
module mreg_seq #(
  parameter int STRETCH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic two_ph,
  input  logic mir0,
  input  logic mir1,
  output logic ph,
  output logic p_mir,
  output logic strobe,
  output logic ready
);

  localparam int            CW   = (STRETCH > 1) ? $clog2(STRETCH) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRETCH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;

  // next-state
  always_comb begin
    p_mir  = ph_q ? mir1 : mir0;
    strobe = req && (!p_mir || (cnt_q == LAST));
    ready  = strobe && (ph_q == two_ph);
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    if (req) begin
      if (ready) begin
        cnt_d = '0;
        ph_d  = 1'b0;
      end else if (strobe) begin
        cnt_d = '0;
        ph_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (req) begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign ph = ph_q;

endmodule

// File: rtl/mreg_route.sv
module mreg_route #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emu_mode,
  input  logic          bus_wr,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  input  logic          mis,
  input  logic          ph,
  input  logic          p_mir,
  input  logic          strobe,
  input  logic          ready,
  output logic [15:0]   bus_rdata,
  output logic          int_en,
  output logic          int_wr,
  output logic [AW-1:0] int_addr,
  output logic [1:0]    int_be,
  output logic [15:0]   int_wdata,
  input  logic [15:0]   int_rdata,
  output logic          emu_en,
  output logic          emu_wr,
  output logic [AW-1:0] emu_addr,
  output logic [1:0]    emu_be,
  output logic [15:0]   emu_wdata,
  input  logic [15:0]   emu_rdata
);

  import mreg_pkg::*;

  logic [AW-1:0] base_lo, base_hi, p_addr;
  logic [1:0]    p_be;
  logic [15:0]   p_wd, src;
  logic          use_ext, lo_en;
  logic [7:0]    lo_q, lo_d;

  assign base_lo = {bus_addr[AW-1:1], 1'b0};
  assign base_hi = {bus_addr[AW-1:1] + 1'b1, 1'b0};

  // per-transfer address, lanes and data
  always_comb begin
    if (mis) begin
      if (!ph) begin
        p_addr = base_lo;
        p_be   = 2'b10;
        p_wd   = lane_put(1'b1, bus_wdata[7:0]);
      end else begin
        p_addr = base_hi;
        p_be   = 2'b01;
        p_wd   = lane_put(1'b0, bus_wdata[15:8]);
      end
    end else if (bus_word) begin
      p_addr = base_lo;
      p_be   = 2'b11;
      p_wd   = bus_wdata;
    end else begin
      p_addr = base_lo;
      p_be   = bus_addr[0] ? 2'b10 : 2'b01;
      p_wd   = lane_put(bus_addr[0], bus_wdata[7:0]);
    end
  end

  // copy selection by mode
  always_comb begin
    use_ext   = emu_mode && p_mir;
    src       = use_ext ? emu_rdata : int_rdata;
    int_en    = strobe && (bus_wr || !use_ext);
    emu_en    = strobe && use_ext;
    int_wr    = bus_wr;
    emu_wr    = bus_wr;
    int_addr  = p_addr;
    emu_addr  = p_addr;
    int_be    = int_en ? p_be : 2'b00;
    emu_be    = emu_en ? p_be : 2'b00;
    int_wdata = p_wd;
    emu_wdata = p_wd;
  end

  // first byte of a split read is held until the second arrives
  always_comb begin
    lo_en = strobe && mis && !ph && !bus_wr;
    lo_d  = lo_en ? src[15:8] : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= 8'h00;
    else        lo_q <= lo_d;
  end

  // read data assembly
  always_comb begin
    bus_rdata = 16'h0000;
    if (ready && !bus_wr) begin
      if (mis)           bus_rdata = {src[7:0], lo_q};
      else if (bus_word) bus_rdata = src;
      else               bus_rdata = {8'h00, bus_addr[0] ? src[15:8] : src[7:0]};
    end
  end

endmodule

// File: rtl/mreg_stretch.sv
module mreg_stretch #(
  parameter int                  AW       = 10,
  parameter int                  STRETCH  = 2,
  parameter int                  N_MIR    = 5,
  parameter logic [N_MIR*AW-1:0] MIR_LIST = {10'h039, 10'h036, 10'h032, 10'h031, 10'h030}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emu_mode,
  input  logic          bus_req,
  input  logic [1:0]    bus_master,
  input  logic          bus_wr,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          bus_ready,
  output logic          cpu_halt,
  output logic          int_en,
  output logic          int_wr,
  output logic [AW-1:0] int_addr,
  output logic [1:0]    int_be,
  output logic [15:0]   int_wdata,
  input  logic [15:0]   int_rdata,
  output logic          emu_en,
  output logic          emu_wr,
  output logic [AW-1:0] emu_addr,
  output logic [1:0]    emu_be,
  output logic [15:0]   emu_wdata,
  input  logic [15:0]   emu_rdata
);

  import mreg_pkg::*;

  logic [AW-1:0] addr_nx;
  logic          hit_lo, hit_hi;
  logic          mis, mir0, mir1, any_mir;
  logic          ph, p_mir, strobe;

  assign addr_nx = bus_addr + 1'b1;

  mreg_match #(.AW(AW), .N(N_MIR), .LIST(MIR_LIST)) u_match_lo (
    .addr (bus_addr),
    .hit  (hit_lo)
  );

  mreg_match #(.AW(AW), .N(N_MIR), .LIST(MIR_LIST)) u_match_hi (
    .addr (addr_nx),
    .hit  (hit_hi)
  );

  // classify the access
  always_comb begin
    mis     = bus_word && bus_addr[0];
    mir0    = (bus_word && !bus_addr[0]) ? (hit_lo || hit_hi) : hit_lo;
    mir1    = hit_hi;
    any_mir = mir0 || (mis && mir1);
  end

  mreg_seq #(.STRETCH(STRETCH)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (bus_req),
    .two_ph (mis),
    .mir0   (mir0),
    .mir1   (mir1),
    .ph     (ph),
    .p_mir  (p_mir),
    .strobe (strobe),
    .ready  (bus_ready)
  );

  mreg_route #(.AW(AW)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .emu_mode  (emu_mode),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mis       (mis),
    .ph        (ph),
    .p_mir     (p_mir),
    .strobe    (strobe),
    .ready     (bus_ready),
    .bus_rdata (bus_rdata),
    .int_en    (int_en),
    .int_wr    (int_wr),
    .int_addr  (int_addr),
    .int_be    (int_be),
    .int_wdata (int_wdata),
    .int_rdata (int_rdata),
    .emu_en    (emu_en),
    .emu_wr    (emu_wr),
    .emu_addr  (emu_addr),
    .emu_be    (emu_be),
    .emu_wdata (emu_wdata),
    .emu_rdata (emu_rdata)
  );

  // R8: halt the CPU for non-CPU accesses to mirrored bytes
  assign cpu_halt = bus_req && (bus_master != MST_CPU) && any_mir;

endmodule

// File: rtl/mreg_stretch_chk.sv
module mreg_stretch_chk #(
  parameter int STRETCH = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        emu_mode,
  input logic        bus_req,
  input logic [1:0]  bus_master,
  input logic        bus_wr,
  input logic        bus_ready,
  input logic        cpu_halt,
  input logic        int_en,
  input logic [1:0]  int_be,
  input logic [15:0] int_wdata,
  input logic        emu_en,
  input logic [1:0]  emu_be,
  input logic [15:0] emu_wdata
);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !bus_ready && !int_en && !emu_en && !cpu_halt);

  a_r9_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en || emu_en) |-> bus_req);

  a_r7_ext_only_emu: assert property (@(posedge clk) disable iff (!rst_n)
    emu_en |-> emu_mode);

  a_r7_read_one_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && emu_en) |-> bus_wr);

  a_r6_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_en && bus_wr) |-> int_en && (int_be == emu_be) && (int_wdata == emu_wdata));

  a_r8_cpu_never: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_master == 2'd0) |-> !cpu_halt);

  if (STRETCH > 1) begin : g_stretch
    a_r2_ext_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      emu_en |-> $past(bus_req) && !$past(bus_ready));
  end

endmodule

bind mreg_stretch mreg_stretch_chk #(.STRETCH(STRETCH)) u_chk (.*);

// File: tb/mreg_stretch_bench.sv
module mreg_stretch_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        emu_mode = 1'b0;
  logic        bus_req = 1'b0;
  logic [1:0]  bus_master = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_word = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ready, cpu_halt;
  logic        int_en, int_wr, emu_en, emu_wr;
  logic [9:0]  int_addr, emu_addr;
  logic [1:0]  int_be, emu_be;
  logic [15:0] int_wdata, emu_wdata, int_rdata, emu_rdata;

  logic [7:0] imem [0:1023];
  logic [7:0] emem [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  mreg_stretch u_mreg_stretch (.*);

  // register file models at the two ports
  assign int_rdata = {imem[int_addr | 10'd1], imem[int_addr]};
  assign emu_rdata = {emem[emu_addr | 10'd1], emem[emu_addr]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) begin
        imem[i] <= 8'((i * 7 + 3) & 255);
        emem[i] <= 8'((i * 13 + 200) & 255);
      end
    end else begin
      if (int_en && int_wr) begin
        if (int_be[0]) imem[int_addr]         <= int_wdata[7:0];
        if (int_be[1]) imem[int_addr | 10'd1] <= int_wdata[15:8];
      end
      if (emu_en && emu_wr) begin
        if (emu_be[0]) emem[emu_addr]         <= emu_wdata[7:0];
        if (emu_be[1]) emem[emu_addr | 10'd1] <= emu_wdata[15:8];
      end
    end
  end

  typedef struct {
    int          lat;
    logic [15:0] rd;
    bit          halt;
    int          nph;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, mchecks = 0, merrors = 0;
  int cyc = 0, stb = 0;
  bit halt_bad = 0;

  localparam logic [9:0] MIRS [5] = '{10'h030, 10'h031, 10'h032, 10'h036, 10'h039};

  function automatic bit is_mir(input logic [9:0] a);
    for (int k = 0; k < 5; k++) if (MIRS[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] pick(input logic [9:0] b, input bit ext);
    return ext ? emem[b] : imem[b];
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // driver: push the expected result, then run the access
  task automatic acc(input string tag, input logic [1:0] m, input logic wr, input logic word,
                     input logic [9:0] a, input logic [15:0] wd, input logic emu);
    exp_t e;
    logic [9:0] a1;
    bit m0, m1, any;
    a1 = a + 10'd1;
    if (word && a[0]) begin
      m0 = is_mir(a); m1 = is_mir(a1);
      e.lat = (m0 ? 2 : 1) + (m1 ? 2 : 1);
      e.rd  = {pick(a1, emu && m1), pick(a, emu && m0)};
      e.nph = 2; any = m0 || m1;
    end else if (word) begin
      m0 = is_mir(a) || is_mir(a1);
      e.lat = m0 ? 2 : 1;
      e.rd  = {pick(a1, emu && m0), pick(a, emu && m0)};
      e.nph = 1; any = m0;
    end else begin
      m0 = is_mir(a);
      e.lat = m0 ? 2 : 1;
      e.rd  = {8'h00, pick(a, emu && m0)};
      e.nph = 1; any = m0;
    end
    if (wr) e.rd = 16'h0000;
    e.halt = any && (m != 2'd0);
    e.tag  = tag;
    q.push_back(e);
    emu_mode = emu; bus_master = m; bus_wr = wr; bus_word = word;
    bus_addr = a; bus_wdata = wd; bus_req = 1'b1;
    do @(negedge clk); while (!bus_ready);
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk({tag, " halt released"}, {15'd0, cpu_halt}, 16'd0);
    @(posedge clk); #1;
  endtask

  // monitor: compare as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (emu_en && !emu_mode) begin
        merrors++;
        $display("FAIL R7 emulation port enabled with emu_mode=0 got 1 exp 0");
      end
      if (bus_req) begin
        cyc++;
        if (int_en || emu_en) stb++;
        if (q.size() > 0 && cpu_halt !== q[0].halt) halt_bad = 1;
        if (bus_ready) begin
          if (q.size() == 0) begin
            merrors++;
            $display("FAIL R9 unexpected ready got 1 exp 0");
          end else begin
            exp_t e;
            e = q.pop_front();
            mchecks += 4;
            if (cyc != e.lat) begin
              merrors++; $display("FAIL %s latency got %0d exp %0d", e.tag, cyc, e.lat);
            end
            if (bus_rdata !== e.rd) begin
              merrors++; $display("FAIL %s rdata got %h exp %h", e.tag, bus_rdata, e.rd);
            end
            if (halt_bad) begin
              merrors++; $display("FAIL %s R8 halt got mismatch exp %0d", e.tag, e.halt);
            end
            if (stb != e.nph) begin
              merrors++; $display("FAIL %s R9 strobes got %0d exp %0d", e.tag, stb, e.nph);
            end
          end
          cyc = 0; stb = 0; halt_bad = 0;
        end
      end
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] old;
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs quiet during reset
    chk("R11 reset outputs", {12'd0, bus_ready, cpu_halt, int_en, emu_en}, 16'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11 idle outputs", {12'd0, bus_ready, cpu_halt, int_en, emu_en}, 16'd0);
    @(posedge clk); #1;

    // R1: unmirrored accesses
    acc("R1 byte read",  2'd0, 1'b0, 1'b0, 10'h100, 16'h0, 1'b1);
    acc("R1 odd byte",   2'd1, 1'b0, 1'b0, 10'h101, 16'h0, 1'b1);
    acc("R1 word read",  2'd2, 1'b0, 1'b1, 10'h100, 16'h0, 1'b0);
    acc("R1 word write", 2'd0, 1'b1, 1'b1, 10'h102, 16'h1234, 1'b1);
    chk("R1 word write data", {imem[10'h103], imem[10'h102]}, 16'h1234);
    // R10: neighbours of listed addresses are not mirrored
    acc("R10 0x033",     2'd1, 1'b0, 1'b0, 10'h033, 16'h0, 1'b1);
    acc("R10 0x037",     2'd1, 1'b0, 1'b0, 10'h037, 16'h0, 1'b1);
    idle("R8 unmirrored");

    // R2: stretched byte and aligned word, both modes
    acc("R2 byte normal", 2'd0, 1'b0, 1'b0, 10'h030, 16'h0, 1'b0);
    acc("R2 byte emu",    2'd0, 1'b0, 1'b0, 10'h030, 16'h0, 1'b1);
    acc("R2 word partial",2'd0, 1'b0, 1'b1, 10'h036, 16'h0, 1'b1);
    acc("R2 word normal", 2'd0, 1'b0, 1'b1, 10'h030, 16'h0, 1'b0);

    // R3, R4, R5: misaligned words
    acc("R3 both mirrored emu",    2'd0, 1'b0, 1'b1, 10'h031, 16'h0, 1'b1);
    acc("R3 both mirrored normal", 2'd0, 1'b0, 1'b1, 10'h031, 16'h0, 1'b0);
    acc("R4 high mirrored",        2'd0, 1'b0, 1'b1, 10'h035, 16'h0, 1'b1);
    acc("R4 low mirrored",         2'd0, 1'b0, 1'b1, 10'h039, 16'h0, 1'b1);
    acc("R4 low unlisted",         2'd0, 1'b0, 1'b1, 10'h02F, 16'h0, 1'b1);
    acc("R5 split unmirrored",     2'd0, 1'b0, 1'b1, 10'h101, 16'h0, 1'b0);
    acc("R5 split write",          2'd0, 1'b1, 1'b1, 10'h105, 16'hC3A5, 1'b0);
    chk("R5 split write bytes", {imem[10'h106], imem[10'h105]}, 16'hC3A5);

    // R6: emulation write hits both copies; debug master halts
    acc("R6 emu word write", 2'd2, 1'b1, 1'b1, 10'h030, 16'hA55A, 1'b1);
    chk("R6 internal copy", {imem[10'h031], imem[10'h030]}, 16'hA55A);
    chk("R6 external copy", {emem[10'h031], emem[10'h030]}, 16'hA55A);
    idle("R8 debug");

    // R7: normal-mode write leaves external copy; reads pick the copy by mode
    old = emem[10'h032];
    acc("R7 normal write", 2'd1, 1'b1, 1'b0, 10'h032, 16'h003C, 1'b0);
    chk("R7 internal updated", {8'h00, imem[10'h032]}, 16'h003C);
    chk("R7 external unchanged", {8'h00, emem[10'h032]}, {8'h00, old});
    acc("R7 emu read",    2'd0, 1'b0, 1'b0, 10'h032, 16'h0, 1'b1);
    acc("R7 normal read", 2'd0, 1'b0, 1'b0, 10'h032, 16'h0, 1'b0);

    // R8: master codes
    acc("R8 cpu write",      2'd0, 1'b1, 1'b0, 10'h036, 16'h0077, 1'b1);
    acc("R8 master3 read",   2'd3, 1'b0, 1'b1, 10'h031, 16'h0, 1'b0);
    idle("R8 master3");
    acc("R8 coproc unmirr",  2'd1, 1'b0, 1'b1, 10'h200, 16'h0, 1'b1);

    // R9: split write with one mirrored byte, back-to-back with a read
    old = emem[10'h03A];
    acc("R9 split write",    2'd1, 1'b1, 1'b1, 10'h039, 16'hBEEF, 1'b1);
    acc("R9 back to back",   2'd2, 1'b0, 1'b1, 10'h039, 16'h0, 1'b1);
    chk("R9 mirrored byte both", {emem[10'h039], imem[10'h039]}, 16'hEFEF);
    chk("R9 plain byte internal", {8'h00, imem[10'h03A]}, 16'h00BE);
    chk("R9 plain byte external", {8'h00, emem[10'h03A]}, {8'h00, old});
    idle("R8 back to back");

    repeat (2) @(posedge clk);
    chk("R9 queue drained", 16'(q.size()), 16'd0);
    summary();
    $finish;
  end

endmodule